// File: doc/BRIEF.md
# I2C Byte Buffer Pair with Level Interrupts

This block holds the bytes that travel between a host (or a DMA channel using the same port) and an I2C byte engine. Bytes bound for the bus enter a transmit queue from the host side. The engine takes the oldest of them only in a cycle where it also reports that the addressed slave acknowledged. Bytes arriving from the bus go into a receive queue, and the host drains that queue in arrival order. Each queue is eight bytes deep by default and reports its current fill level.

Five sticky interrupt causes are kept in one status vector:
- transmit level at or below a programmable threshold;
- receive level at or above a programmable threshold;
- engine request while the transmit queue is empty;
- a received byte dropped because the receive queue is full;
- a host write refused because the transmit side is locked.

The engine locks the transmit side, for example after a NACK or a lost arbitration. Only a transmit flush releases the lock. Status bits are cleared by writing 1. A per-bit enable decides which causes drive the single interrupt line.

Top module: `i2cq_fifo_pair`

## Requirements
- R1: During and straight after reset, both levels read 0, `tx_locked` is 0, `irq_status` is all zero and `irq` is 0.
- R2: Host writes enter the transmit queue in order, up to DEPTH (8) bytes. A write while `tx_level` is 8 and the lock is clear is discarded, and the level stays 8.
- R3: A byte leaves the transmit queue only in a cycle with `eng_tx_req`, `eng_tx_ack` and a non-zero level. In that cycle `eng_tx_vld` is 1 and `eng_tx_data` holds the oldest byte. A request without ack leaves the level unchanged.
- R4: `eng_tx_req` while `tx_level` is 0 sets status bit 2 (transmit underflow) at the next clock edge.
- R5: A pulse on `eng_tx_lock` sets `tx_locked`. While it is set, host writes are discarded and set status bit 4. `tx_flush` empties the transmit queue and clears the lock at the next edge.
- R6: Engine pushes enter the receive queue in order, up to 8 bytes. A push while `rx_level` is 8 is dropped, leaves the stored bytes intact and sets status bit 3 (receive overflow).
- R7: On either queue, a push and a pop accepted in the same cycle leave the level unchanged.
- R8: Status bit 0 is set one edge after a cycle in which `tx_level` <= `tx_thresh`.
- R9: Status bit 1 is set one edge after a cycle in which `rx_level` >= `rx_thresh`.
- R10: A 1 in `irq_clr` clears that status bit unless its cause is present in the same cycle, in which case the bit stays set. Bits written with 0 keep their value.
- R11: `irq` is 1 exactly when some status bit is 1 and its `irq_en` bit is also 1.
- R12: `rx_flush` empties the receive queue at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_tx_wr | input | 1 | Host/DMA write strobe for the transmit queue |
| host_tx_data | input | DW | Byte to write |
| host_rx_rd | input | 1 | Host/DMA read strobe; pops the receive head |
| host_rx_data | output | DW | Oldest byte in the receive queue |
| eng_tx_req | input | 1 | Engine asks for the next transmit byte |
| eng_tx_ack | input | 1 | Addressed slave acknowledged; qualifies the release |
| eng_tx_data | output | DW | Oldest transmit byte |
| eng_tx_vld | output | 1 | A byte is released this cycle |
| eng_tx_lock | input | 1 | Engine pulse that locks host writes |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | DW | Received byte |
| tx_flush | input | 1 | Empties the transmit queue and clears the lock |
| rx_flush | input | 1 | Empties the receive queue |
| tx_thresh | input | LW | Transmit level threshold |
| rx_thresh | input | LW | Receive level threshold |
| irq_clr | input | 5 | Write-1-to-clear strobes for the status bits |
| irq_en | input | 5 | Per-bit interrupt enables |
| tx_level | output | LW | Bytes held in the transmit queue |
| rx_level | output | LW | Bytes held in the receive queue |
| tx_locked | output | 1 | Transmit lock state |
| irq_status | output | 5 | Sticky interrupt causes |
| irq | output | 1 | OR of the enabled status bits |

## Verification
The bench drives each queue past full. A design that wrapped its pointers or kept the ninth byte would show a wrong level, or wrong data when the queue is drained. It requests bytes without an acknowledge and against an empty queue; a release that ignored the ack would lose a byte, and a missed underflow would leave bit 2 clear. It attempts writes while locked and pushes and pops in the same cycle; a level counter that counts only one of the two would drift. It checks the cycle on which a threshold bit rises, and it clears a bit whose cause is still present; letting the clear win there would hide a live condition.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
   localparam int IRQ_N     = 5;
   localparam int IRQ_TXTHR = 0;
   localparam int IRQ_RXTHR = 1;
   localparam int IRQ_TXUND = 2;
   localparam int IRQ_RXOVF = 3;
   localparam int IRQ_TXLCK = 4;
endpackage

// File: rtl/i2cq_ring.sv
module i2cq_ring #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [LW-1:0] level
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign head = mem[rd_ptr];
endmodule

// File: rtl/i2cq_irq.sv
module i2cq_irq #(
   parameter int IW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] cause,
   input  logic [IW-1:0] clr,
   input  logic [IW-1:0] en,
   output logic [IW-1:0] status,
   output logic          irq
);
   generate
      for (genvar b = 0; b < IW; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        status[b] <= 1'b0;
            else if (cause[b]) status[b] <= 1'b1;
            else if (clr[b])   status[b] <= 1'b0;
         end
      end
   endgenerate

   assign irq = |(status & en);
endmodule

// File: rtl/i2cq_fifo_pair.sv
module i2cq_fifo_pair
   import i2cq_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_tx_wr,
   input  logic [DW-1:0]    host_tx_data,
   input  logic             host_rx_rd,
   output logic [DW-1:0]    host_rx_data,
   input  logic             eng_tx_req,
   input  logic             eng_tx_ack,
   output logic [DW-1:0]    eng_tx_data,
   output logic             eng_tx_vld,
   input  logic             eng_tx_lock,
   input  logic             eng_rx_push,
   input  logic [DW-1:0]    eng_rx_data,
   input  logic             tx_flush,
   input  logic             rx_flush,
   input  logic [LW-1:0]    tx_thresh,
   input  logic [LW-1:0]    rx_thresh,
   input  logic [IRQ_N-1:0] irq_clr,
   input  logic [IRQ_N-1:0] irq_en,
   output logic [LW-1:0]    tx_level,
   output logic [LW-1:0]    rx_level,
   output logic             tx_locked,
   output logic [IRQ_N-1:0] irq_status,
   output logic             irq
);
   initial begin
      assert (DEPTH >= 2) else $fatal(1, "DEPTH must be at least 2");
      assert (DW >= 1)    else $fatal(1, "DW must be at least 1");
   end

   logic tx_full, tx_empty, rx_full, rx_empty;
   logic tx_push, tx_pop, rx_push, rx_pop;
   logic [IRQ_N-1:0] cause;

   assign tx_full  = (tx_level == LW'(DEPTH));
   assign tx_empty = (tx_level == '0);
   assign rx_full  = (rx_level == LW'(DEPTH));
   assign rx_empty = (rx_level == '0);

   assign tx_push = host_tx_wr && !tx_flush && !tx_locked && !tx_full;
   assign tx_pop  = eng_tx_req && eng_tx_ack && !tx_empty && !tx_flush;
   assign rx_push = eng_rx_push && !rx_full && !rx_flush;
   assign rx_pop  = host_rx_rd && !rx_empty && !rx_flush;

   assign eng_tx_vld = tx_pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           tx_locked <= 1'b0;
      else if (tx_flush)    tx_locked <= 1'b0;
      else if (eng_tx_lock) tx_locked <= 1'b1;
   end

   i2cq_ring #(.DEPTH(DEPTH), .DW(DW)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tx_flush),
      .push  (tx_push),
      .din   (host_tx_data),
      .pop   (tx_pop),
      .head  (eng_tx_data),
      .level (tx_level)
   );

   i2cq_ring #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_flush),
      .push  (rx_push),
      .din   (eng_rx_data),
      .pop   (rx_pop),
      .head  (host_rx_data),
      .level (rx_level)
   );

   always_comb begin
      cause            = '0;
      cause[IRQ_TXTHR] = (tx_level <= tx_thresh);
      cause[IRQ_RXTHR] = (rx_level >= rx_thresh);
      cause[IRQ_TXUND] = eng_tx_req && tx_empty;
      cause[IRQ_RXOVF] = eng_rx_push && rx_full;
      cause[IRQ_TXLCK] = host_tx_wr && tx_locked;
   end

   i2cq_irq #(.IW(IRQ_N)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .cause  (cause),
      .clr    (irq_clr),
      .en     (irq_en),
      .status (irq_status),
      .irq    (irq)
   );
endmodule

// File: rtl/i2cq_fifo_pair_chk.sv
module i2cq_fifo_pair_chk #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_tx_wr,
   input logic          host_rx_rd,
   input logic          eng_tx_req,
   input logic          eng_tx_ack,
   input logic          eng_rx_push,
   input logic          tx_flush,
   input logic          rx_flush,
   input logic [LW-1:0] tx_thresh,
   input logic [LW-1:0] rx_thresh,
   input logic [4:0]    irq_en,
   input logic [LW-1:0] tx_level,
   input logic [LW-1:0] rx_level,
   input logic          tx_locked,
   input logic [4:0]    irq_status,
   input logic          irq
);
   AST_TX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LW'(DEPTH)); // R2
   AST_NO_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_tx_ack && !host_tx_wr && !tx_flush) |=> $stable(tx_level)); // R3
   AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_req && tx_level == '0) |=> irq_status[2]); // R4
   AST_LOCK_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_locked && host_tx_wr && !tx_flush) |=> (tx_level <= $past(tx_level))); // R5
   AST_FLUSH_TX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> (tx_level == '0 && !tx_locked)); // R5
   AST_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && rx_level == LW'(DEPTH)) |=> irq_status[3]); // R6
   AST_RX_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && host_rx_rd && !rx_flush && rx_level != '0 &&
       rx_level != LW'(DEPTH)) |=> $stable(rx_level)); // R7
   AST_TX_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= tx_thresh) |=> irq_status[0]); // R8
   AST_RX_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level >= rx_thresh) |=> irq_status[1]); // R9
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en == '0) |-> !irq); // R11
   AST_FLUSH_RX: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> (rx_level == '0)); // R12
endmodule

bind i2cq_fifo_pair i2cq_fifo_pair_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/i2cq_fifo_pair_tb.sv
module i2cq_fifo_pair_tb_top;
   localparam int DEPTH = 8;
   localparam int DW    = 8;
   localparam int LW    = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_tx_wr = 1'b0, host_rx_rd = 1'b0;
   logic [DW-1:0] host_tx_data = '0, eng_rx_data = '0;
   logic [DW-1:0] host_rx_data, eng_tx_data;
   logic          eng_tx_req = 1'b0, eng_tx_ack = 1'b0, eng_tx_lock = 1'b0;
   logic          eng_rx_push = 1'b0, tx_flush = 1'b0, rx_flush = 1'b0;
   logic          eng_tx_vld, tx_locked, irq;
   logic [LW-1:0] tx_thresh = '0, rx_thresh = 4'd8;
   logic [LW-1:0] tx_level, rx_level;
   logic [4:0]    irq_clr = '0, irq_en = '0, irq_status;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   i2cq_fifo_pair #(.DEPTH(DEPTH), .DW(DW)) dut_i (.*);

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      chk(tx_level == 0, "R1 tx_level", tx_level, 0);
      chk(rx_level == 0, "R1 rx_level", rx_level, 0);
      chk(irq_status == 0, "R1 status", irq_status, 0);
      chk(!irq && !tx_locked, "R1 irq/lock", {irq, tx_locked}, 0);
      repeat (2) tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_tx_order();
      for (int i = 0; i < 9; i++) begin
         host_tx_wr = 1'b1; host_tx_data = 8'hA0 + 8'(i);
         tick();
      end
      host_tx_wr = 1'b0;
      chk(tx_level == 8, "R2 full level after 9 writes", tx_level, 8);
      eng_tx_req = 1'b1; eng_tx_ack = 1'b0;
      #1;
      chk(!eng_tx_vld, "R3 no release without ack", eng_tx_vld, 0);
      tick();
      chk(tx_level == 8, "R3 level held without ack", tx_level, 8);
      eng_tx_ack = 1'b1;
      for (int i = 0; i < 8; i++) begin
         #1;
         chk(eng_tx_vld && eng_tx_data == 8'hA0 + 8'(i), "R3 released byte",
             eng_tx_data, 8'hA0 + i);
         tick();
      end
      eng_tx_req = 1'b0; eng_tx_ack = 1'b0;
      chk(tx_level == 0, "R3 drained", tx_level, 0);
      chk(irq_status[2] == 0, "R4 no underflow yet", irq_status[2], 0);
      eng_tx_req = 1'b1;
      tick();
      eng_tx_req = 1'b0;
      chk(irq_status[2] == 1, "R4 underflow bit", irq_status[2], 1);
      irq_clr = 5'b00100;
      tick();
      irq_clr = '0;
      chk(irq_status[2:0] == 3'b001, "R10 clear one bit only", irq_status[2:0], 3'b001);
   endtask

   task automatic t_lock();
      for (int i = 0; i < 2; i++) begin
         host_tx_wr = 1'b1; host_tx_data = 8'h10 + 8'(i);
         tick();
      end
      host_tx_wr = 1'b0; eng_tx_lock = 1'b1;
      tick();
      eng_tx_lock = 1'b0;
      chk(tx_locked, "R5 lock set", tx_locked, 1);
      host_tx_wr = 1'b1; host_tx_data = 8'hEE;
      tick();
      host_tx_wr = 1'b0;
      chk(tx_level == 2, "R5 locked write discarded", tx_level, 2);
      chk(irq_status[4], "R5 lock bit", irq_status[4], 1);
      tx_flush = 1'b1;
      tick();
      tx_flush = 1'b0;
      chk(tx_level == 0 && !tx_locked, "R5 flush empties and unlocks",
          {tx_locked, tx_level}, 0);
      host_tx_wr = 1'b1; host_tx_data = 8'h77;
      tick();
      host_tx_wr = 1'b0;
      #1;
      chk(tx_level == 1 && eng_tx_data == 8'h77, "R5 write after unlock",
          eng_tx_data, 8'h77);
      tx_flush = 1'b1;
      tick();
      tx_flush = 1'b0;
   endtask

   task automatic t_rx();
      for (int i = 0; i < 9; i++) begin
         eng_rx_push = 1'b1; eng_rx_data = 8'h30 + 8'(i);
         tick();
      end
      eng_rx_push = 1'b0;
      chk(rx_level == 8, "R6 rx full level", rx_level, 8);
      chk(irq_status[3], "R6 overflow bit", irq_status[3], 1);
      for (int i = 0; i < 8; i++) begin
         chk(host_rx_data == 8'h30 + 8'(i), "R6 rx order", host_rx_data, 8'h30 + i);
         host_rx_rd = 1'b1;
         tick();
         host_rx_rd = 1'b0;
      end
      chk(rx_level == 0, "R6 dropped byte not stored", rx_level, 0);
   endtask

   task automatic t_same_cycle();
      for (int i = 0; i < 3; i++) begin
         eng_rx_push = 1'b1; eng_rx_data = 8'h50 + 8'(i);
         tick();
      end
      eng_rx_data = 8'h53; host_rx_rd = 1'b1;
      tick();
      eng_rx_push = 1'b0; host_rx_rd = 1'b0;
      chk(rx_level == 3, "R7 rx push+pop level", rx_level, 3);
      chk(host_rx_data == 8'h51, "R7 rx head advanced", host_rx_data, 8'h51);
      rx_flush = 1'b1;
      tick();
      rx_flush = 1'b0;
      chk(rx_level == 0, "R12 rx flush", rx_level, 0);
      for (int i = 0; i < 2; i++) begin
         host_tx_wr = 1'b1; host_tx_data = 8'h60 + 8'(i);
         tick();
      end
      host_tx_data = 8'h62; eng_tx_req = 1'b1; eng_tx_ack = 1'b1;
      tick();
      host_tx_wr = 1'b0; eng_tx_req = 1'b0; eng_tx_ack = 1'b0;
      chk(tx_level == 2, "R7 tx push+pop level", tx_level, 2);
      tx_flush = 1'b1;
      tick();
      tx_flush = 1'b0;
   endtask

   task automatic t_thresh();
      tx_thresh = 4'd2;
      for (int i = 0; i < 3; i++) begin
         host_tx_wr = 1'b1; host_tx_data = 8'h40 + 8'(i);
         tick();
      end
      host_tx_wr = 1'b0; irq_clr = 5'b00001;
      tick();
      irq_clr = '0;
      tick();
      chk(irq_status[0] == 0, "R8 above threshold stays clear", irq_status[0], 0);
      eng_tx_req = 1'b1; eng_tx_ack = 1'b1;
      tick();
      eng_tx_req = 1'b0; eng_tx_ack = 1'b0;
      chk(irq_status[0] == 0, "R8 not yet set", irq_status[0], 0);
      tick();
      chk(irq_status[0] == 1, "R8 set one edge later", irq_status[0], 1);
      irq_clr = 5'b00001;
      tick();
      irq_clr = '0;
      chk(irq_status[0] == 1, "R10 live cause beats clear", irq_status[0], 1);
      tx_flush = 1'b1; tx_thresh = '0;
      tick();
      tx_flush = 1'b0;
      rx_thresh = 4'd3; irq_clr = 5'b00010;
      tick();
      irq_clr = '0;
      for (int i = 0; i < 2; i++) begin
         eng_rx_push = 1'b1; eng_rx_data = 8'h20;
         tick();
      end
      eng_rx_push = 1'b0;
      tick();
      chk(irq_status[1] == 0, "R9 below threshold clear", irq_status[1], 0);
      eng_rx_push = 1'b1;
      tick();
      eng_rx_push = 1'b0;
      chk(irq_status[1] == 0, "R9 not yet set", irq_status[1], 0);
      tick();
      chk(irq_status[1] == 1, "R9 set one edge later", irq_status[1], 1);
      rx_flush = 1'b1; rx_thresh = 4'd8;
      tick();
      rx_flush = 1'b0;
   endtask

   task automatic t_irq();
      irq_clr = 5'b11111;
      tick();
      irq_clr = '0;
      tick();
      chk(irq_status == 5'b00001, "R10 clear all but live bit", irq_status, 5'b00001);
      irq_en = 5'b00010;
      #1;
      chk(!irq, "R11 masked bit", irq, 0);
      irq_en = 5'b00001;
      #1;
      chk(irq, "R11 enabled bit", irq, 1);
      irq_en = '0;
      #1;
      chk(!irq, "R11 all masked", irq, 0);
   endtask

   initial begin
      t_reset();
      t_tx_order();
      t_lock();
      t_rx();
      t_same_cycle();
      t_thresh();
      t_irq();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule